// File: doc/BRIEF.md
# Multi-Size ALU with Status Flags

A purely combinational arithmetic and logic unit for a small microcontroller core whose data path is 20 bits wide but whose instructions may work on bytes, 16-bit words or full 20-bit quantities. The core hands it a destination operand, a source operand, an operation code, a size code and its current status word. The ALU returns the result, a flag telling the core whether that result is to be written back, the four condition flags it computed, a mask saying which of those flags the operation is allowed to change, and the status word with those flags merged in.

Two-operand operations cover binary add and subtract (with and without carry), compare, packed-decimal add and the bitwise operations AND, bit-test, bit-clear, bit-set and exclusive-OR. One-operand operations, which act on the destination operand, cover rotate right through carry, arithmetic and logical shift right, byte swap and sign extension from a byte. Flag rules follow the core's conventions: logic operations report "result nonzero" in the carry flag, and exclusive-OR raises overflow only when both operands are negative.

Top module: `alu_core`

## Requirements
- R1: `size_i` selects the width: 0 = 8 bits, 1 = 16 bits, 2 and 3 = 20 bits. Operand bits above the selected width are ignored, and result bits above it read zero for every operation except byte swap and sign extension.
- R2: Add (`op_i`=0) and add-with-carry (`op_i`=1, carry-in = `status_i[0]`) produce the sum at the selected width; C is set when the unsigned sum does not fit, V when the signed sum overflows, N is the top bit of the selected width, Z is set when the result is zero at that width.
- R3: Subtract (`op_i`=2) computes dst + inverted src + 1, subtract-with-carry (`op_i`=3) uses `status_i[0]` in place of the 1, and compare (`op_i`=4) computes as subtract; C, V, N and Z follow the R2 rules on that sum.
- R4: `wb_o` is 0 for compare (`op_i`=4) and bit-test (`op_i`=7) and 1 for every other operation.
- R5: Decimal add (`op_i`=5) adds the operands as packed BCD digits plus `status_i[0]`; C is set when the decimal sum exceeds 99 (byte), 9999 (16-bit) or 99999 (20-bit). It updates N, Z and C only.
- R6: AND (`op_i`=6) and bit-test (`op_i`=7) compute dst AND src, set C when the result is nonzero, clear V and set N and Z from the result.
- R7: Exclusive-OR (`op_i`=10) sets C when the result is nonzero and sets V only when the sign bits of both operands are set.
- R8: Bit-clear (`op_i`=8, dst AND NOT src), bit-set (`op_i`=9, dst OR src) and byte swap (`op_i`=14, bytes of dst[15:0] exchanged, bits 19:16 zero) leave every flag unchanged.
- R9: Rotate-through-carry (`op_i`=11) shifts dst right and inserts `status_i[0]` at the top bit of the selected width; arithmetic shift (`op_i`=12) keeps the sign bit; logical shift (`op_i`=13) inserts zero. All three move dst bit 0 into C and clear V.
- R10: Sign extension (`op_i`=15) copies dst bit 7 across all 20 result bits; N and Z come from the result at the selected width, C is set when that result is nonzero and V is cleared.
- R11: `flags_o` and `flag_upd_o` order the flags as {V, N, Z, C} in bits 3..0; a bit of `flags_o` whose update bit is 0 reads 0.
- R12: `status_o` equals `status_i` except that each updated flag is written to its status position: V to bit 8, N to bit 2, Z to bit 1, C to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 20 | Destination operand (sole operand of one-operand ops) |
| src_i | input | 20 | Source operand |
| status_i | input | 16 | Current status word; bit 0 is the incoming carry |
| result_o | output | 20 | Operation result |
| wb_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | Computed flags {V, N, Z, C} |
| flag_upd_o | output | 4 | Flags changed by this operation {V, N, Z, C} |
| status_o | output | 16 | Status word with updated flags merged |

## Verification
Every output is a function of the present inputs only, so each result is due in the same cycle as its stimulus, zero clock edges later. The bench drives a new operation just after a rising edge and samples all five outputs at the following falling edge, by which time the combinational paths have settled and no edge ordering is involved. Expected status words are rebuilt in the bench from the expected flags and mask, so the merge positions are checked on every vector.

// File: rtl/alu_pkg.sv
package alu_pkg;

  parameter int unsigned ALU_W   = 20;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned WORD_W  = 16;
  parameter int unsigned DIGIT_W = 4;
  parameter int unsigned STAT_W  = 16;
  parameter int unsigned FLAG_N  = 4;

  localparam int unsigned N_DIGITS   = ALU_W / DIGIT_W;
  localparam int unsigned BYTE_DIGS  = BYTE_W / DIGIT_W;
  localparam int unsigned WORD_DIGS  = WORD_W / DIGIT_W;

  // flag vector positions
  localparam int unsigned FV = 3;
  localparam int unsigned FN = 2;
  localparam int unsigned FZ = 1;
  localparam int unsigned FC = 0;

  typedef logic [ALU_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RRA  = 4'd12,
    OP_RRU  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_ADDR = 2'd2,
    SZ_WIDE = 2'd3
  } alu_size_e;

  function automatic word_t size_mask(alu_size_e s);
    word_t m = '0;
    case (s)
      SZ_BYTE: m[BYTE_W-1:0] = '1;
      SZ_WORD: m[WORD_W-1:0] = '1;
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic word_t top_bit(alu_size_e s);
    word_t t = '0;
    case (s)
      SZ_BYTE: t[BYTE_W-1] = 1'b1;
      SZ_WORD: t[WORD_W-1] = 1'b1;
      default: t[ALU_W-1]  = 1'b1;
    endcase
    return t;
  endfunction

  function automatic logic sign_at(word_t v, alu_size_e s);
    return |(v & top_bit(s));
  endfunction

  // status-word bit that holds flag index f
  function automatic int unsigned stat_pos(int unsigned f);
    case (f)
      FV:      return 8;
      FN:      return 2;
      FZ:      return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [FLAG_N-1:0] upd_for(alu_op_e op);
    case (op)
      OP_DADD:                   return 4'b0111;
      OP_BIC, OP_BIS, OP_SWPB:   return 4'b0000;
      default:                   return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder
  import alu_pkg::*;
(
  input  word_t     a_i,
  input  word_t     b_i,
  input  logic      inv_b_i,
  input  logic      cin_i,
  input  alu_size_e size_i,
  output word_t     sum_o,
  output logic      c_o,
  output logic      v_o
);
  word_t            m;
  word_t            bx;
  logic [ALU_W:0]   raw;
  logic             sa, sb, sr;

  always_comb begin
    m   = size_mask(size_i);
    bx  = inv_b_i ? (~b_i & m) : b_i;
    raw = {1'b0, a_i} + {1'b0, bx} + {{ALU_W{1'b0}}, cin_i};
    sum_o = raw[ALU_W-1:0] & m;
    case (size_i)
      SZ_BYTE: c_o = raw[BYTE_W];
      SZ_WORD: c_o = raw[WORD_W];
      default: c_o = raw[ALU_W];
    endcase
    sa  = sign_at(a_i, size_i);
    sb  = sign_at(bx, size_i);
    sr  = sign_at(sum_o, size_i);
    v_o = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_bcd_adder.sv
module alu_bcd_adder
  import alu_pkg::*;
(
  input  word_t             a_i,
  input  word_t             b_i,
  input  logic              cin_i,
  input  alu_size_e         size_i,
  output word_t             sum_o,
  output logic              c_o
);
  logic [N_DIGITS:0] cy;
  word_t             raw;

  assign cy[0] = cin_i;

  for (genvar d = 0; d < N_DIGITS; d++) begin : g_dig
    logic [DIGIT_W:0] s;
    logic             ge10;
    always_comb begin
      s    = {1'b0, a_i[d*DIGIT_W +: DIGIT_W]} + {1'b0, b_i[d*DIGIT_W +: DIGIT_W]}
           + {{DIGIT_W{1'b0}}, cy[d]};
      ge10 = (s >= (DIGIT_W+1)'(10));
      raw[d*DIGIT_W +: DIGIT_W] = ge10 ? DIGIT_W'(s - (DIGIT_W+1)'(10)) : s[DIGIT_W-1:0];
    end
    assign cy[d+1] = ge10;
  end

  always_comb begin
    sum_o = raw & size_mask(size_i);
    case (size_i)
      SZ_BYTE: c_o = cy[BYTE_DIGS];
      SZ_WORD: c_o = cy[WORD_DIGS];
      default: c_o = cy[N_DIGITS];
    endcase
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_pkg::*;
(
  input  alu_op_e   op_i,
  input  alu_size_e size_i,
  input  word_t     a_i,
  input  word_t     b_i,
  input  word_t     dst_raw_i,
  input  logic      cin_i,
  output word_t     res_o,
  output logic      c_o,
  output logic      v_o
);
  word_t m;

  always_comb begin
    m     = size_mask(size_i);
    res_o = '0;
    c_o   = 1'b0;
    v_o   = 1'b0;
    case (op_i)
      OP_AND, OP_BIT: begin
        res_o = a_i & b_i;
        c_o   = |res_o;
      end
      OP_BIC: res_o = a_i & ~b_i;
      OP_BIS: res_o = a_i | b_i;
      OP_XOR: begin
        res_o = a_i ^ b_i;
        c_o   = |res_o;
        v_o   = sign_at(a_i, size_i) & sign_at(b_i, size_i);
      end
      OP_RRC: begin
        res_o = (a_i >> 1) | (cin_i ? top_bit(size_i) : '0);
        c_o   = a_i[0];
      end
      OP_RRA: begin
        res_o = (a_i >> 1) | (a_i & top_bit(size_i));
        c_o   = a_i[0];
      end
      OP_RRU: begin
        res_o = a_i >> 1;
        c_o   = a_i[0];
      end
      OP_SWPB: res_o = {{(ALU_W-WORD_W){1'b0}}, dst_raw_i[BYTE_W-1:0], dst_raw_i[WORD_W-1:BYTE_W]};
      OP_SXT: begin
        res_o = {{(ALU_W-BYTE_W){dst_raw_i[BYTE_W-1]}}, dst_raw_i[BYTE_W-1:0]};
        c_o   = |(res_o & m);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [ALU_W-1:0]  dst_i,
  input  logic [ALU_W-1:0]  src_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [ALU_W-1:0]  result_o,
  output logic              wb_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] flag_upd_o,
  output logic [STAT_W-1:0] status_o
);
  alu_op_e   op;
  alu_size_e sz;
  word_t     m, a, b;
  logic      cin_st;

  assign op     = alu_op_e'(op_i);
  assign sz     = alu_size_e'(size_i);
  assign m      = size_mask(sz);
  assign a      = dst_i & m;
  assign b      = src_i & m;
  assign cin_st = status_i[0];

  // arithmetic path
  logic  inv_b, add_cin, add_c, add_v;
  word_t add_sum;

  always_comb begin
    inv_b   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    case (op)
      OP_ADD:          add_cin = 1'b0;
      OP_SUB, OP_CMP:  add_cin = 1'b1;
      default:         add_cin = cin_st;
    endcase
  end

  alu_adder u_add (
    .a_i(a), .b_i(b), .inv_b_i(inv_b), .cin_i(add_cin), .size_i(sz),
    .sum_o(add_sum), .c_o(add_c), .v_o(add_v)
  );

  word_t bcd_sum;
  logic  bcd_c;

  alu_bcd_adder u_bcd (
    .a_i(a), .b_i(b), .cin_i(cin_st), .size_i(sz),
    .sum_o(bcd_sum), .c_o(bcd_c)
  );

  word_t bit_res;
  logic  bit_c, bit_v;

  alu_bitops u_bit (
    .op_i(op), .size_i(sz), .a_i(a), .b_i(b), .dst_raw_i(dst_i), .cin_i(cin_st),
    .res_o(bit_res), .c_o(bit_c), .v_o(bit_v)
  );

  // result and flag selection
  word_t             res;
  logic              c_sel, v_sel;
  logic [FLAG_N-1:0] fl, upd;

  always_comb begin
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res = add_sum; c_sel = add_c; v_sel = add_v;
      end
      OP_DADD: begin
        res = bcd_sum; c_sel = bcd_c; v_sel = 1'b0;
      end
      default: begin
        res = bit_res; c_sel = bit_c; v_sel = bit_v;
      end
    endcase
    upd     = upd_for(op);
    fl      = '0;
    fl[FV]  = v_sel;
    fl[FN]  = sign_at(res, sz);
    fl[FZ]  = ((res & m) == '0);
    fl[FC]  = c_sel;
  end

  assign result_o   = res;
  assign wb_o       = !((op == OP_CMP) || (op == OP_BIT));
  assign flags_o    = fl & upd;
  assign flag_upd_o = upd;

  // status merge, one bit per status position
  for (genvar g = 0; g < STAT_W; g++) begin : g_sr
    always_comb begin
      status_o[g] = status_i[g];
      for (int f = 0; f < FLAG_N; f++)
        if (upd[f] && (stat_pos(f) == g)) status_o[g] = fl[f];
    end
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
(
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic [STAT_W-1:0] status_i,
  input logic [ALU_W-1:0]  result_o,
  input logic              wb_o,
  input logic [FLAG_N-1:0] flags_o,
  input logic [FLAG_N-1:0] flag_upd_o,
  input logic [STAT_W-1:0] status_o
);
  localparam logic [STAT_W-1:0] FLAG_POS = 16'h0107;
  word_t m;
  assign m = size_mask(alu_size_e'(size_i));

  always_comb begin
    assert_upper_clear_R1: assert ((op_i == OP_SXT) || (op_i == OP_SWPB) || ((result_o & ~m) == '0))
      else $error("result bits above size not zero");
    assert_zero_flag_R2: assert (!flag_upd_o[FZ] || (flags_o[FZ] == ((result_o & m) == '0)))
      else $error("Z flag disagrees with result");
    assert_neg_flag_R2: assert (!flag_upd_o[FN] || (flags_o[FN] == |(result_o & top_bit(alu_size_e'(size_i)))))
      else $error("N flag disagrees with result");
    assert_no_wb_R4: assert (wb_o == !((op_i == OP_CMP) || (op_i == OP_BIT)))
      else $error("write-back enable wrong");
    assert_dadd_no_v_R5: assert ((op_i != OP_DADD) || !flag_upd_o[FV])
      else $error("decimal add touches V");
    assert_quiet_flags_R8: assert (!((op_i == OP_BIC) || (op_i == OP_BIS) || (op_i == OP_SWPB))
                                   || ((flag_upd_o == '0) && (status_o == status_i)))
      else $error("flag-neutral op changed status");
    assert_flags_masked_R11: assert ((flags_o & ~flag_upd_o) == '0)
      else $error("flag set outside update mask");
    assert_status_keep_R12: assert ((status_o & ~FLAG_POS) == (status_i & ~FLAG_POS))
      else $error("non-flag status bit changed");
    assert_carry_merge_R12: assert (!flag_upd_o[FC] || (status_o[0] == flags_o[FC]))
      else $error("carry not merged");
  end
endmodule

bind alu_core alu_core_chk u_chk (
  .op_i(op_i), .size_i(size_i), .status_i(status_i), .result_o(result_o),
  .wb_o(wb_o), .flags_o(flags_o), .flag_upd_o(flag_upd_o), .status_o(status_o)
);

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  op_i;
  logic [1:0]  size_i;
  logic [19:0] dst_i, src_i;
  logic [15:0] status_i;
  logic [19:0] result_o;
  logic        wb_o;
  logic [3:0]  flags_o, flag_upd_o;
  logic [15:0] status_o;

  alu_core dut (
    .op_i(op_i), .size_i(size_i), .dst_i(dst_i), .src_i(src_i), .status_i(status_i),
    .result_o(result_o), .wb_o(wb_o), .flags_o(flags_o), .flag_upd_o(flag_upd_o),
    .status_o(status_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic        cin;
    logic [19:0] a;
    logic [19:0] b;
    logic [19:0] res;
    logic [3:0]  flg;
    logic [3:0]  upd;
    logic        wb;
    int          req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 2'd1,1'b0,20'h07FFF,20'h00001,20'h08000,4'b1100,4'hF,1'b1,2},  // R2 signed overflow
    '{4'd0, 2'd0,1'b0,20'h123FF,20'h00001,20'h00000,4'b0011,4'hF,1'b1,1},  // R1 upper bits ignored
    '{4'd1, 2'd2,1'b1,20'hFFFFF,20'h00000,20'h00000,4'b0011,4'hF,1'b1,2},  // R2 carry-in
    '{4'd2, 2'd1,1'b0,20'h00005,20'h00007,20'h0FFFE,4'b0100,4'hF,1'b1,3},  // R3 borrow
    '{4'd2, 2'd1,1'b0,20'h08000,20'h00001,20'h07FFF,4'b1001,4'hF,1'b1,3},  // R3 overflow
    '{4'd3, 2'd0,1'b0,20'h00010,20'h00010,20'h000FF,4'b0100,4'hF,1'b1,3},  // R3 subc cin 0
    '{4'd4, 2'd1,1'b0,20'h01234,20'h01234,20'h00000,4'b0011,4'hF,1'b0,4},  // R4 compare
    '{4'd5, 2'd1,1'b0,20'h00999,20'h00001,20'h01000,4'b0000,4'h7,1'b1,5},  // R5
    '{4'd5, 2'd0,1'b0,20'h00099,20'h00001,20'h00000,4'b0011,4'h7,1'b1,5},  // R5 byte > 99
    '{4'd5, 2'd1,1'b1,20'h09999,20'h00000,20'h00000,4'b0011,4'h7,1'b1,5},  // R5 word > 9999
    '{4'd5, 2'd2,1'b0,20'h45678,20'h54321,20'h99999,4'b0100,4'h7,1'b1,5},  // R5 20-bit
    '{4'd6, 2'd1,1'b0,20'h0F0F0,20'h08F00,20'h08000,4'b0101,4'hF,1'b1,6},  // R6
    '{4'd7, 2'd0,1'b0,20'h0000F,20'h000F0,20'h00000,4'b0010,4'hF,1'b0,6},  // R6 bit-test
    '{4'd8, 2'd1,1'b0,20'h0FFFF,20'h000F0,20'h0FF0F,4'b0000,4'h0,1'b1,8},  // R8 bic
    '{4'd9, 2'd0,1'b0,20'h00001,20'h00080,20'h00081,4'b0000,4'h0,1'b1,8},  // R8 bis
    '{4'd10,2'd1,1'b0,20'h08001,20'h08000,20'h00001,4'b1001,4'hF,1'b1,7},  // R7 both negative
    '{4'd10,2'd0,1'b0,20'h00080,20'h00001,20'h00081,4'b0101,4'hF,1'b1,7},  // R7 one negative
    '{4'd11,2'd1,1'b1,20'h00001,20'h00000,20'h08000,4'b0101,4'hF,1'b1,9},  // R9 rrc
    '{4'd11,2'd0,1'b0,20'h00002,20'h00000,20'h00001,4'b0000,4'hF,1'b1,9},  // R9 rrc
    '{4'd12,2'd0,1'b0,20'h00081,20'h00000,20'h000C0,4'b0101,4'hF,1'b1,9},  // R9 rra byte
    '{4'd12,2'd2,1'b0,20'h80000,20'h00000,20'hC0000,4'b0100,4'hF,1'b1,9},  // R9 rra 20-bit
    '{4'd13,2'd1,1'b0,20'h08001,20'h00000,20'h04000,4'b0001,4'hF,1'b1,9},  // R9 rru
    '{4'd14,2'd2,1'b0,20'hA1234,20'h00000,20'h03412,4'b0000,4'h0,1'b1,8},  // R8 swpb
    '{4'd15,2'd1,1'b0,20'h00080,20'h00000,20'hFFF80,4'b0101,4'hF,1'b1,10}, // R10 negative
    '{4'd15,2'd2,1'b0,20'h0007F,20'h00000,20'h0007F,4'b0001,4'hF,1'b1,10}, // R10 positive
    '{4'd15,2'd1,1'b0,20'hFFF00,20'h00000,20'h00000,4'b0010,4'hF,1'b1,10}, // R10 zero
    '{4'd0, 2'd3,1'b0,20'hFFFFF,20'h00001,20'h00000,4'b0011,4'hF,1'b1,1}   // R1 size 3
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input logic [15:0] st,
                                             input logic [3:0] flg, input logic [3:0] upd);
    logic [15:0] r = st;
    if (upd[3]) r[8] = flg[3];
    if (upd[2]) r[2] = flg[2];
    if (upd[1]) r[1] = flg[1];
    if (upd[0]) r[0] = flg[0];
    return r;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [1:0] sz, input logic [19:0] a,
                       input logic [19:0] b, input logic [15:0] st);
    @(posedge clk);
    #1;
    op_i = op; size_i = sz; dst_i = a; src_i = b; status_i = st;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    op_i = '0; size_i = '0; dst_i = '0; src_i = '0; status_i = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // quiescent inputs: byte add of zeros gives zero result with only Z raised (R2, R12)
    @(negedge clk);
    chk(result_o == 20'h0, 2, "idle result", 32'(result_o), 32'h0);
    chk(flags_o == 4'b0010, 2, "idle flags", 32'(flags_o), 32'h2);
    chk(status_o == 16'h0002, 12, "idle status", 32'(status_o), 32'h2);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [15:0] st;
      st = 16'h5BFE | {15'h0, VECS[i].cin};
      drive(VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b, st);
      chk(result_o == VECS[i].res, VECS[i].req, $sformatf("vec%0d result", i),
          32'(result_o), 32'(VECS[i].res));
      chk(flags_o == VECS[i].flg, 11, $sformatf("vec%0d flags", i),
          32'(flags_o), 32'(VECS[i].flg));
      chk(flag_upd_o == VECS[i].upd, VECS[i].req, $sformatf("vec%0d mask", i),
          32'(flag_upd_o), 32'(VECS[i].upd));
      chk(wb_o == VECS[i].wb, 4, $sformatf("vec%0d wb", i), 32'(wb_o), 32'(VECS[i].wb));
      chk(status_o == exp_status(st, VECS[i].flg, VECS[i].upd), 12,
          $sformatf("vec%0d status", i), 32'(status_o),
          32'(exp_status(st, VECS[i].flg, VECS[i].upd)));
    end

    // R8: bit-set with all status bits high leaves status untouched
    drive(4'd9, 2'd1, 20'h00F00, 20'h000F0, 16'hFFFF);
    chk(status_o == 16'hFFFF, 8, "bis status kept", 32'(status_o), 32'hFFFF);
    chk(result_o == 20'h00FF0, 8, "bis result", 32'(result_o), 32'h00FF0);

    // R12: word add 1+1 with all status high clears V,N,Z,C positions only
    drive(4'd0, 2'd1, 20'h00001, 20'h00001, 16'hFFFF);
    chk(status_o == 16'hFEF8, 12, "clear flag positions", 32'(status_o), 32'hFEF8);

    // R5: decimal add keeps V in status
    drive(4'd5, 2'd0, 20'h00012, 20'h00034, 16'h0100);
    chk(result_o == 20'h00046, 5, "dadd result", 32'(result_o), 32'h46);
    chk(status_o == 16'h0100, 5, "dadd V kept", 32'(status_o), 32'h0100);

    // R3: subtract-with-carry, carry in 1 behaves as plain subtract
    drive(4'd3, 2'd1, 20'h00009, 20'h00004, 16'h0001);
    chk(result_o == 20'h00005, 3, "subc cin1", 32'(result_o), 32'h5);
    chk(flags_o == 4'b0001, 3, "subc flags", 32'(flags_o), 32'h1);

    // R1: 20-bit add ignores nothing, byte compare ignores upper bits
    drive(4'd4, 2'd0, 20'hABC05, 20'h12305, 16'h0000);
    chk(flags_o == 4'b0011, 1, "byte cmp equal", 32'(flags_o), 32'h3);
    chk(wb_o == 1'b0, 4, "cmp no wb", 32'(wb_o), 32'h0);

    // R9: rotate through carry at 20-bit inserts carry at bit 19
    drive(4'd11, 2'd2, 20'h00000, 20'h00000, 16'h0001);
    chk(result_o == 20'h80000, 9, "rrc 20-bit", 32'(result_o), 32'h80000);
    chk(flags_o == 4'b0100, 9, "rrc 20-bit flags", 32'(flags_o), 32'h4);

    finish_run();
  end
endmodule